// File: doc/BRIEF.md
# Unsigned Carry-Save Array Multiplier

This block multiplies two unsigned operands of N bits each and returns their full product of 2N bits. It is built as a square grid of identical cells. Each cell forms one partial-product bit with an AND gate and adds that bit, the partial sum from the row above and a saved carry into a full adder. Carries do not ripple along a row. Each row hands its carries down to the next row at one place value higher. After the last row, one N-bit ripple-carry adder combines the remaining sums and carries. That adder forms the upper half of the product.

The lower N product bits come straight out of the array. Bit j is the least significant sum output of row j. The arithmetic is purely combinational. A single output register captures the product on each rising clock edge, so the product of the operands present at an edge appears at the output after that edge. The operand width is a parameter, and the grid is built with generate loops around one cell module.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of operands present at a rising clock edge with reset low, `product` after that edge equals `mcand * mplier` as an unsigned 2N-bit value.
- R2: `product` changes only at a rising clock edge. A change of the operands between edges leaves `product` unchanged until the next edge, so the latency is exactly one cycle.
- R3: When `rst` is high at a rising edge, `product` becomes zero after that edge, whatever the operands are. The reset is synchronous.
- R4: If either operand is zero at an edge, `product` is zero after that edge.
- R5: If one operand is 1, `product` equals the other operand, with the upper N bits zero.
- R6: When both operands are all ones, `product` equals (2^N-1)^2. For N=8 this is 16'hFE01, and for N=4 it is 8'hE1.
- R7: `product` never exceeds (2^N-1)^2 once reset has been applied.
- R8: Bit 0 of `product` equals the AND of bit 0 of both operands sampled at the previous edge.
- R9: The same RTL with N=4 gives the correct product for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the product register |
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier |
| product | output | 2N | Registered unsigned product |

## Verification
Each result is due exactly one rising edge after its operands are applied, and a reset is due after the edge at which `rst` is high. The bench drives the operands at falling edges. A behavioural model captures the expected value at each rising edge, and the bench compares it with the output at the next falling edge. The latency check also samples just after new operands are applied, before the next rising edge, to confirm that the output still holds the previous result.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;
  // Width of the full product for an operand width n.
  function automatic int prod_width(input int n);
    return 2 * n;
  endfunction

  // Flat index of the cell at row j, column i in an n-wide grid.
  function automatic int cell_idx(input int n, input int j, input int i);
    return j * n + i;
  endfunction
endpackage

// File: rtl/csa_full_add.sv
module csa_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end
endmodule

// File: rtl/csa_pp_cell.sv
module csa_pp_cell (
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);
  logic pp_bit;

  assign pp_bit = a_bit & b_bit;

  csa_full_add u_fa (
    .x  (pp_bit),
    .y  (sum_in),
    .ci (carry_in),
    .s  (sum_out),
    .co (carry_out)
  );
endmodule

// File: rtl/csa_cell_array.sv
module csa_cell_array #(
  parameter int N = 8
) (
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [N-1:0] low_bits,
  output logic [N-1:0] last_sum,
  output logic [N-1:0] last_carry
);
  import csa_mult_pkg::*;

  localparam int CELLS = N * N;

  logic [CELLS-1:0] s_flat;
  logic [CELLS-1:0] c_flat;

  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar i = 0; i < N; i++) begin : g_col
      logic sin;
      logic cin;
      if (j == 0) begin : g_first
        assign sin = 1'b0;
        assign cin = 1'b0;
      end else begin : g_inner
        if (i == N - 1) begin : g_top
          assign sin = 1'b0;
        end else begin : g_mid
          assign sin = s_flat[cell_idx(N, j - 1, i + 1)];
        end
        assign cin = c_flat[cell_idx(N, j - 1, i)];
      end

      csa_pp_cell u_cell (
        .a_bit     (mcand[i]),
        .b_bit     (mplier[j]),
        .sum_in    (sin),
        .carry_in  (cin),
        .sum_out   (s_flat[cell_idx(N, j, i)]),
        .carry_out (c_flat[cell_idx(N, j, i)])
      );
    end
    assign low_bits[j] = s_flat[cell_idx(N, j, 0)];
  end

  assign last_sum   = s_flat[CELLS-1 -: N];
  assign last_carry = c_flat[CELLS-1 -: N];
endmodule

// File: rtl/csa_ripple_add.sv
module csa_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  logic [W-1:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    csa_full_add u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (c[i]),
      .s  (s[i]),
      .co (c[i+1])
    );
  end

  // Top bit: the product fits in 2N bits, so its carry-out is never needed.
  assign s[W-1] = x[W-1] ^ y[W-1] ^ c[W-1];
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         mcand,
  input  logic [N-1:0]         mplier,
  output logic [2*N-1:0]       product
);
  import csa_mult_pkg::*;

  localparam int PW = prod_width(N);

  logic [N-1:0]  low_bits;
  logic [N-1:0]  last_sum;
  logic [N-1:0]  last_carry;
  logic [N-1:0]  high_bits;
  logic [PW-1:0] prod_comb;

  csa_cell_array #(.N(N)) u_array (
    .mcand      (mcand),
    .mplier     (mplier),
    .low_bits   (low_bits),
    .last_sum   (last_sum),
    .last_carry (last_carry)
  );

  // Sum bit 0 of the last row is already product bit N-1, so the rest shift down.
  csa_ripple_add #(.W(N)) u_final (
    .x (({1'b0, last_sum} >> 1)),
    .y (last_carry),
    .s (high_bits)
  );

  assign prod_comb = {high_bits, low_bits};

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
    end else begin
      product <= prod_comb;
    end
  end
endmodule

// File: rtl/csa_array_mult_chk.sv
module csa_array_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] product
);
  localparam logic [2*N-1:0] MAXP = {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1};

  logic primed = 1'b0;
  logic past_rst = 1'b0;

  always_ff @(posedge clk) begin
    primed   <= !rst;
    past_rst <= rst;
  end

  // R1
  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    primed |-> product == ({{N{1'b0}}, $past(mcand)} * {{N{1'b0}}, $past(mplier)}));

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (primed && $stable(mcand) && $stable(mplier) && $past(primed)) |=> $stable(product));

  // R3
  p_reset_r3: assert property (@(posedge clk) disable iff (rst)
    past_rst |-> product == '0);

  // R4
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (primed && ($past(mcand) == '0 || $past(mplier) == '0)) |-> product == '0);

  // R7
  p_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (primed || past_rst) |-> product <= MAXP);

  // R8
  p_lsb_r8: assert property (@(posedge clk) disable iff (rst)
    primed |-> product[0] == ($past(mcand[0]) & $past(mplier[0])));
endmodule

bind csa_array_mult csa_array_mult_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mcand   (mcand),
  .mplier  (mplier),
  .product (product)
);

// File: tb/csa_array_mult_test.sv
module csa_array_mult_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  csa_array_mult #(.N(8)) uut (
    .clk(clk), .rst(rst), .mcand(a8), .mplier(b8), .product(p8));

  csa_array_mult #(.N(4)) uut_n4 (
    .clk(clk), .rst(rst), .mcand(a4), .mplier(b4), .product(p4));

  // Behavioural reference: expected outputs registered each rising edge.
  logic [15:0] e8 = '0;
  logic [7:0]  e4 = '0;
  bit ev = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      e8 <= '0;
      e4 <= '0;
    end else begin
      e8 <= 16'(a8) * 16'(b8);
      e4 <= 8'(a4) * 8'(b4);
    end
    ev <= 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R1 for N=8, R9 for N=4, R7 bound).
  always @(negedge clk) begin
    if (ev && !done) begin
      chk("R1", int'(p8), int'(e8));
      chk("R9", int'(p4), int'(e4));
      chk("R7", int'(p8 <= 16'hFE01), 1);
    end
  end

  task automatic vec8(input logic [7:0] a, input logic [7:0] b, input string req,
                      input int exp);
    @(negedge clk);
    a8 = a;
    b8 = b;
    @(negedge clk);
    #1;
    chk(req, int'(p8), exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R3: reset with nonzero operands gives zero.
    a8 = 8'h37; b8 = 8'h5A; a4 = 4'h9; b4 = 4'h7;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R3", int'(p8), 0);
    chk("R3", int'(p4), 0);
    rst = 1'b0;

    // R2: one-cycle latency, output held between edges.
    vec8(8'd12, 8'd10, "R2", 120);
    a8 = 8'd200;
    b8 = 8'd3;
    #1;
    chk("R2", int'(p8), 120);
    @(negedge clk);
    #1;
    chk("R2", int'(p8), 600);

    // R9: exhaustive N=4 alongside random N=8 (R1).
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      a4 = i[7:4];
      b4 = i[3:0];
      a8 = 8'($urandom);
      b8 = 8'($urandom);
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      a8 = 8'($urandom);
      b8 = 8'($urandom);
    end

    // R6: all ones on both widths.
    @(negedge clk);
    a4 = 4'hF;
    b4 = 4'hF;
    vec8(8'hFF, 8'hFF, "R6", 16'hFE01);
    chk("R6", int'(p4), 8'hE1);

    // R4: zero operand.
    vec8(8'h00, 8'hFF, "R4", 0);
    vec8(8'hA5, 8'h00, "R4", 0);

    // R5: multiply by one.
    vec8(8'h01, 8'hC3, "R5", 16'h00C3);
    vec8(8'h7E, 8'h01, "R5", 16'h007E);

    // R8: low product bit.
    vec8(8'h81, 8'h03, "R8", 16'h0183);
    chk("R8", int'(p8[0]), 1);
    vec8(8'h80, 8'hFF, "R8", 16'h7F80);
    chk("R8", int'(p8[0]), 0);

    // R3: reset in mid-run with all-ones operands.
    @(negedge clk);
    a8 = 8'hFF;
    b8 = 8'hFF;
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R3", int'(p8), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", int'(p8), 16'hFE01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule